// File: doc/BRIEF.md
# Serial Address and Mode Controller

This block sits in front of a video sequential-access memory array. It takes a row address and a combined column/mode word, each arriving one bit at a time on its own line and sampled on rising edges of a dedicated address clock. A falling edge of the RAM-enable input captures both words. The two top bits of the column word select one of four operations: load read latch A, load read latch B, write from the input latch to the array, or refresh one row.

A captured command does not run at once. It runs at the next RAM-enable falling edge, so software can shift in the address for cycle N+1 while cycle N is still running. Read and refresh strobes fire at that falling edge. The write strobe waits for the following rising edge of RAM-enable. Refresh ignores the supplied address and takes its row from an internal counter that wraps at the last row. A watchdog flags a missing refresh. After reset, the first few RAM-enable cycles are treated as a warm-up and start no operation.

All inputs are sampled on the system clock, and edges are found by comparing each input with its value one clock earlier.

Top module: `sam_addr_ctrl`

## Requirements
- R1: The row word and the column/mode word are shifted in LSB first on each rising edge of `adr_clk`. When more than 8 edges come before a capture, only the last 8 bits are kept.
- R2: A falling edge of `ram_en` captures both words. The command captured at one falling edge runs at the next falling edge and not earlier.
- R3: Column bits [5:0] form the column. Bit 7 is M1 and bit 6 is M0. {M1,M0} = 00 loads latch A, 01 loads latch B, 10 writes, and 11 refreshes. `op_out` carries the same 2-bit code.
- R4: A read command raises `load_a_stb` or `load_b_stb` for exactly one clock at the falling edge where it runs, with `row_out` and `col_out` holding its address.
- R5: A write command raises `wr_stb` for exactly one clock at the next rising edge of `ram_en`.
- R6: A refresh raises `refresh_stb` for one clock with `row_out` equal to the internal row counter and `col_out` zero, whatever address was shifted in. The counter then advances by one.
- R7: The refresh row counter counts 0 to REF_ROWS-1 (211 by default) and then wraps to 0.
- R8: The first INIT_CYCLES (8) falling edges after reset start no operation. `init_done` rises at the 8th, and the word captured there runs at the 9th.
- R9: `refresh_late` rises once TIMEOUT_CYC clocks pass after `init_done` with no refresh. The next refresh clears it.
- R10: After reset all strobes, `init_done`, `refresh_late`, `row_out`, `col_out` and `op_out` are zero.
- R11: At most one strobe is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adr_clk | input | 1 | Address shift clock, sampled; rising edges shift |
| row_sdi | input | 1 | Serial row address bit |
| colmode_sdi | input | 1 | Serial column/mode bit |
| ram_en | input | 1 | RAM-enable; falling edge captures and runs, rising edge ends a cycle |
| row_out | output | 8 | Row of the running operation |
| col_out | output | 6 | Column of the running operation |
| op_out | output | 2 | Code of the running operation ({M1,M0}) |
| load_a_stb | output | 1 | One-clock strobe: load latch A |
| load_b_stb | output | 1 | One-clock strobe: load latch B |
| wr_stb | output | 1 | One-clock strobe: write latch C to memory |
| refresh_stb | output | 1 | One-clock strobe: refresh row `row_out` |
| init_done | output | 1 | Warm-up cycles complete |
| refresh_late | output | 1 | No refresh within the timeout |

## Verification
The main function is driven with each of the four mode codes, using complementary row and column patterns (0x5A/0xA5, all ones, all zeros). These show whether bits are swapped, reversed or taken from the wrong line. A refresh driven with a non-zero junk address tells the internal counter apart from the supplied row. A cycle with four extra leading bits tells "keep the last eight" apart from "keep the first eight". A long chain of more than 212 refreshes exposes the wrap point. The warm-up phase is driven with valid read commands, so any strobe in that phase stands out against the queue of expected operations. An idle stretch longer than the timeout, followed by a refresh, checks that the late flag is both raised and cleared.

// File: rtl/sam_adr_pkg.sv
package sam_adr_pkg;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 6;
    localparam int MODE_W = 2;
    localparam int WORD_W = COL_W + MODE_W;

    typedef enum logic [MODE_W-1:0] {
        OP_RD_A = 2'b00,
        OP_RD_B = 2'b01,
        OP_WR   = 2'b10,
        OP_REF  = 2'b11
    } op_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        op_e              op;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [ROW_W-1:0] r,
                                        input logic [WORD_W-1:0] w);
        cmd_t c;
        c.row = r;
        c.col = w[COL_W-1:0];
        c.op  = op_e'(w[WORD_W-1 -: MODE_W]);
        return c;
    endfunction
endpackage

// File: rtl/sam_shift_in.sv
module sam_shift_in #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= {din, q[W-1:1]};
    end
endmodule

// File: rtl/sam_refresh_ctr.sv
module sam_refresh_ctr
    import sam_adr_pkg::*;
#(
    parameter int ROWS    = 212,
    parameter int TIMEOUT = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             advance,
    output logic [ROW_W-1:0] row_idx,
    output logic             late
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst)          row_idx <= '0;
        else if (advance) row_idx <= (row_idx == LAST) ? '0 : row_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !arm || advance)  tmr <= '0;
        else if (tmr != TW'(TIMEOUT)) tmr <= tmr + 1'b1;
    end

    assign late = (tmr == TW'(TIMEOUT));

    a_r7_row_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(row_idx) < ROWS);
    a_r6_row_moves: assert property (@(posedge clk) disable iff (rst)
        advance |=> row_idx != $past(row_idx));
    a_r9_late_clears: assert property (@(posedge clk) disable iff (rst)
        advance |=> !late);
endmodule

// File: rtl/sam_addr_ctrl.sv
module sam_addr_ctrl
    import sam_adr_pkg::*;
#(
    parameter int REF_ROWS    = 212,
    parameter int INIT_CYCLES = 8,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adr_clk,
    input  logic             row_sdi,
    input  logic             colmode_sdi,
    input  logic             ram_en,
    output logic [ROW_W-1:0] row_out,
    output logic [COL_W-1:0] col_out,
    output logic [1:0]       op_out,
    output logic             load_a_stb,
    output logic             load_b_stb,
    output logic             wr_stb,
    output logic             refresh_stb,
    output logic             init_done,
    output logic             refresh_late
);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);

    logic adr_q, ren_q;
    logic adr_rise, ren_fall, ren_rise;
    logic [ROW_W-1:0]  row_sr;
    logic [WORD_W-1:0] word_sr;
    logic [INIT_W-1:0] init_cnt;
    cmd_t pend;
    logic pend_vld, exec, wr_pend, advance;
    op_e  op_q;
    logic [ROW_W-1:0] ref_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            adr_q <= 1'b0;
            ren_q <= 1'b1;
        end else begin
            adr_q <= adr_clk;
            ren_q <= ram_en;
        end
    end

    assign adr_rise = adr_clk & ~adr_q;
    assign ren_fall = ~ram_en & ren_q;
    assign ren_rise = ram_en & ~ren_q;

    sam_shift_in #(.W(ROW_W)) u_row_sr (
        .clk(clk), .rst(rst), .shift_en(adr_rise), .din(row_sdi), .q(row_sr));
    sam_shift_in #(.W(WORD_W)) u_word_sr (
        .clk(clk), .rst(rst), .shift_en(adr_rise), .din(colmode_sdi), .q(word_sr));

    assign init_done = (init_cnt == INIT_W'(INIT_CYCLES));
    assign exec      = ren_fall & init_done & pend_vld;
    assign advance   = exec && (pend.op == OP_REF);

    always_ff @(posedge clk) begin
        if (rst) begin
            init_cnt <= '0;
            pend     <= '0;
            pend_vld <= 1'b0;
        end else if (ren_fall) begin
            if (!init_done) init_cnt <= init_cnt + 1'b1;
            pend     <= decode_cmd(row_sr, word_sr);
            pend_vld <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_out     <= '0;
            col_out     <= '0;
            op_q        <= OP_RD_A;
            load_a_stb  <= 1'b0;
            load_b_stb  <= 1'b0;
            refresh_stb <= 1'b0;
            wr_stb      <= 1'b0;
            wr_pend     <= 1'b0;
        end else begin
            load_a_stb  <= exec && (pend.op == OP_RD_A);
            load_b_stb  <= exec && (pend.op == OP_RD_B);
            refresh_stb <= advance;
            wr_stb      <= ren_rise && wr_pend;
            if (exec) begin
                op_q <= pend.op;
                if (pend.op == OP_REF) begin
                    row_out <= ref_row;
                    col_out <= '0;
                end else begin
                    row_out <= pend.row;
                    col_out <= pend.col;
                end
            end
            if (exec && pend.op == OP_WR) wr_pend <= 1'b1;
            else if (ren_rise)            wr_pend <= 1'b0;
        end
    end

    assign op_out = op_q;

    sam_refresh_ctr #(.ROWS(REF_ROWS), .TIMEOUT(TIMEOUT_CYC)) u_ref (
        .clk(clk), .rst(rst), .arm(init_done), .advance(advance),
        .row_idx(ref_row), .late(refresh_late));

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_a_stb, load_b_stb, wr_stb, refresh_stb}));
    a_r8_quiet_warmup: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !(load_a_stb | load_b_stb | wr_stb | refresh_stb));
    a_r4_load_a_single: assert property (@(posedge clk) disable iff (rst)
        load_a_stb |=> !load_a_stb);
    a_r3_load_a_code: assert property (@(posedge clk) disable iff (rst)
        load_a_stb |-> op_out == OP_RD_A);
    a_r3_load_b_code: assert property (@(posedge clk) disable iff (rst)
        load_b_stb |-> op_out == OP_RD_B);
    a_r5_write_on_rise: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(ram_en) && op_out == OP_WR);
    a_r6_refresh_col_zero: assert property (@(posedge clk) disable iff (rst)
        refresh_stb |-> col_out == '0 && op_out == OP_REF);
endmodule

// File: tb/sim_sam_addr_ctrl.sv
module sim_sam_addr_ctrl;
    localparam int ROWS = 212;
    localparam int INIT = 8;
    localparam int TMO  = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adr_clk = 1'b0, row_sdi = 1'b0, colmode_sdi = 1'b0, ram_en = 1'b1;
    logic [7:0] row_out;
    logic [5:0] col_out;
    logic [1:0] op_out;
    logic load_a_stb, load_b_stb, wr_stb, refresh_stb, init_done, refresh_late;

    always #2.5 clk = ~clk;

    sam_addr_ctrl #(.REF_ROWS(ROWS), .INIT_CYCLES(INIT), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .adr_clk(adr_clk), .row_sdi(row_sdi),
        .colmode_sdi(colmode_sdi), .ram_en(ram_en), .row_out(row_out),
        .col_out(col_out), .op_out(op_out), .load_a_stb(load_a_stb),
        .load_b_stb(load_b_stb), .wr_stb(wr_stb), .refresh_stb(refresh_stb),
        .init_done(init_done), .refresh_late(refresh_late));

    typedef struct { int kind; int row; int col; } exp_t;
    exp_t q[$];

    int n_chk = 0, n_fail = 0;
    int exp_ref = 0, falls = 0;
    bit pv = 0;
    logic [7:0] pr, pw;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: shift extra junk bits, then 8 real bits, then one RAM-enable cycle
    task automatic re_cycle(input logic [7:0] r, input logic [7:0] w, input int extra);
        exp_t e;
        for (int i = 0; i < extra; i++) begin
            row_sdi = 1'b1; colmode_sdi = 1'b1; adr_clk = 1'b0; @(negedge clk);
            adr_clk = 1'b1; @(negedge clk);
        end
        for (int i = 0; i < 8; i++) begin
            row_sdi = r[i]; colmode_sdi = w[i]; adr_clk = 1'b0; @(negedge clk);
            adr_clk = 1'b1; @(negedge clk);
        end
        adr_clk = 1'b0;
        if (falls >= INIT && pv) begin
            e.kind = int'(pw[7:6]);
            if (e.kind == 3) begin
                e.row = exp_ref; e.col = 0;
                exp_ref = (exp_ref + 1) % ROWS;
            end else begin
                e.row = int'(pr); e.col = int'(pw[5:0]);
            end
            q.push_back(e);
        end
        pr = r; pw = w; pv = 1; falls++;
        ram_en = 1'b0; repeat (3) @(negedge clk);
        ram_en = 1'b1; repeat (2) @(negedge clk);
    endtask

    // monitor: pop and compare on every strobe
    always @(negedge clk) begin
        if (!rst) begin
            int k;
            exp_t e;
            k = load_a_stb ? 0 : load_b_stb ? 1 : wr_stb ? 2 : refresh_stb ? 3 : -1;
            if ($countones({load_a_stb, load_b_stb, wr_stb, refresh_stb}) > 1)
                check(0, "R11 strobes", 2, 1);
            if (k >= 0) begin
                if (q.size() == 0) begin
                    check(0, "R8/R2 unexpected strobe", k, -1);
                end else begin
                    e = q.pop_front();
                    check(k == e.kind, "R3 operation", k, e.kind);
                    check(int'(row_out) == e.row, "R4/R6/R7 row", row_out, e.row);
                    check(int'(col_out) == e.col, "R4/R6 column", col_out, e.col);
                    check(int'(op_out) == k, "R3 op_out code", op_out, k);
                    if (k == 2) check(ram_en == 1'b1, "R5 write at rise", ram_en, 1);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check({load_a_stb, load_b_stb, wr_stb, refresh_stb} == 4'b0, "R10 strobes", 0, 0);
        check(init_done == 1'b0, "R10 init_done", init_done, 0);
        check(refresh_late == 1'b0, "R10 refresh_late", refresh_late, 0);
        check(row_out == 8'h00 && col_out == 6'h00 && op_out == 2'b00, "R10 outputs",
              {row_out, col_out, op_out}, 0);

        // R8 warm-up: valid reads that must be ignored
        for (int i = 0; i < INIT; i++) begin
            re_cycle(8'(i + 1), 8'h00 | 8'(i), 0);
            if (i == INIT - 2) check(init_done == 1'b0, "R8 not done early", init_done, 0);
        end
        check(init_done == 1'b1, "R8 done after 8th", init_done, 1);

        // main patterns; each cycle runs the previous one (R2)
        re_cycle(8'h5A, {2'b00, 6'h15}, 0);   // runs last warm-up word (R8)
        re_cycle(8'hA5, {2'b01, 6'h2A}, 0);
        check(row_out == 8'h5A, "R2 pipeline delay", row_out, 8'h5A);
        re_cycle(8'hFF, {2'b10, 6'h3F}, 0);
        re_cycle(8'hC3, {2'b11, 6'h11}, 0);   // refresh with junk address (R6)
        re_cycle(8'h00, {2'b00, 6'h00}, 4);   // extra bits ahead (R1)
        re_cycle(8'h3C, {2'b01, 6'h07}, 7);   // R1 keep last eight
        re_cycle(8'h81, {2'b10, 6'h21}, 0);
        check(op_out == 2'b01 && row_out == 8'h3C, "R1 last eight bits", row_out, 8'h3C);

        // R7 wrap: run past the last row
        for (int i = 0; i < ROWS + 4; i++) re_cycle(8'hEE, 8'hFF, 0);
        check(exp_ref == 4, "R7 wrap count", exp_ref, 4);
        check(refresh_late == 1'b0, "R9 clear after refresh", refresh_late, 0);

        // R9 timeout
        repeat (TMO + 50) @(negedge clk);
        check(refresh_late == 1'b1, "R9 late raised", refresh_late, 1);
        re_cycle(8'h12, {2'b00, 6'h01}, 0);   // pending refresh runs here
        check(refresh_late == 1'b0, "R9 late cleared", refresh_late, 0);
        re_cycle(8'h34, {2'b11, 6'h02}, 0);   // flush the read

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R2 all expected operations seen", q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule